// File: doc/BRIEF.md
# Secure Boot Decision Controller

This block runs once after every reset and settles how the part comes up. It reads a small set of words from the configuration page through a flash read port and asks an external CRC engine to check two things: the stored key-hash and the user image. It also looks at a blank-flash status flag and samples a boot-mode pin. From these results it applies a layered policy that decides three things: whether the debug port opens, which class of flash access is granted, and whether the part jumps to user code or enters the serial downloader. It also hands the stored write-protect word to the flash controller's protection register.

The policy has a recovery rule. When the image CRC check is enabled and fails, debug is opened even on a read-protected part. Flash stays sealed except for mass erase, so a corrupted image can be wiped without exposing its contents. Once a mass erase finishes, the flash reads as blank and the next reset takes the blank path. Until the sequence completes, every policy output is held in its most restrictive value. After that a done flag rises and the outputs stay fixed until the next reset.

Top module: `boot_policy_ctrl`

## Requirements
- R1: When `flash_blank` is high in the first cycle after reset, no read or CRC request is issued and no write-protect load occurs. The block finishes with `dbg_en`=1, `acc_class`=2 (full) and `go_loader`=1, whatever the level of `boot_pin`.
- R2: A key-hash whose four words (offsets 0x180, 0x184, 0x188, 0x18C) are all 0xFFFFFFFF, together with a passing key-hash CRC, means the part is unprotected, and `dbg_en` is 1.
- R3: A key-hash with any word other than 0xFFFFFFFF, or a failing key-hash CRC, means the part is protected. When the image check passes, `dbg_en` is then 0.
- R4: The image check passes when the image CRC engine reports success, or when the stored image CRC word is 0xFFFFFFFF. In the second case no image CRC request is made. A passing image check gives `acc_class`=2 (full).
- R5: The image check fails when the CRC engine reports failure, or when the page-count word at offset 0x194 exceeds MAX_PAGE. A failing check gives `acc_class`=1 (mass erase only) and `go_user`=0.
- R6: A protected part whose image check fails opens debug for recovery: `dbg_en`=1 with `acc_class`=1.
- R7: On a non-blank part, `boot_pin` is sampled in the first cycle after reset. A low level selects the downloader. A high level selects user code only when the image check passes, and the downloader otherwise. Once done, exactly one of `go_user` and `go_loader` is 1.
- R8: On a non-blank part, the word read from offset 0x19C appears on `wp_word` with a single-cycle `wp_load` pulse. The pulse comes before `done` rises, and each bit of the word guards four consecutive pages.
- R9: Until `done` rises (and during reset), `dbg_en`=0, `acc_class`=0, `go_user`=0 and `go_loader`=0. After `done` rises, it and the outputs hold until reset.
- R10: Reads are issued in this order: 0x180, 0x184, 0x188, 0x18C, 0x194. Then comes the stored image CRC at N*0x800+0x7FC, but only when the page count N is valid. Then comes 0x19C. The image CRC request carries N on `crc_last_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flash_blank | input | 1 | Whole user flash reads as erased |
| boot_pin | input | 1 | Boot-mode pin, low selects the downloader |
| rd_req | output | 1 | Flash read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | One-cycle read response strobe |
| rd_data | input | 32 | Read data |
| crc_req | output | 1 | CRC engine request, held until `crc_done` |
| crc_img | output | 1 | 0 checks the key-hash, 1 checks the image |
| crc_last_page | output | PAGE_W | Last page covered by the image CRC |
| crc_done | input | 1 | One-cycle CRC completion strobe |
| crc_ok | input | 1 | CRC result, valid with `crc_done` |
| wp_load | output | 1 | Load strobe for the protection register |
| wp_word | output | 32 | Write-protect word |
| dbg_en | output | 1 | Debug port enable |
| acc_class | output | 2 | 0 none, 1 mass erase only, 2 full |
| go_user | output | 1 | Jump to user code |
| go_loader | output | 1 | Enter the serial downloader |
| done | output | 1 | Decision complete |

## Verification
The assertions rely on a few conditions about the inputs. `rd_valid` and `crc_done` each arrive as a single-cycle strobe, and only while the matching request is held. `flash_blank` is stable across the first cycle after reset. The bench responders honour these conditions: they answer each request exactly once, after a fixed latency, and clear their strobe on the following cycle. They hold `flash_blank` and `boot_pin` constant for a whole reset interval. The responders also check every read address and the CRC page argument against a queue built from the scenario.

// File: rtl/boot_policy_ctrl.sv
module boot_policy_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 2048,
  parameter int MAX_PAGE   = 127,
  localparam int PAGE_W    = $clog2(MAX_PAGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_blank,
  input  logic              boot_pin,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              crc_req,
  output logic              crc_img,
  output logic [PAGE_W-1:0] crc_last_page,
  input  logic              crc_done,
  input  logic              crc_ok,
  output logic              wp_load,
  output logic [31:0]       wp_word,
  output logic              dbg_en,
  output logic [1:0]        acc_class,
  output logic              go_user,
  output logic              go_loader,
  output logic              done
);

  localparam logic [1:0] ACC_NONE  = 2'd0;
  localparam logic [1:0] ACC_ERASE = 2'd1;
  localparam logic [1:0] ACC_FULL  = 2'd2;
  localparam logic [ADDR_W-1:0] PG      = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] KH_OFS  = ADDR_W'(32'h180);
  localparam logic [ADDR_W-1:0] LEN_OFS = ADDR_W'(32'h194);
  localparam logic [ADDR_W-1:0] WP_OFS  = ADDR_W'(32'h19C);
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    ST_BOOT, ST_KH, ST_KHCRC, ST_LEN, ST_ICRCW, ST_ICRC, ST_WP, ST_FINAL, ST_DONE
  } state_t;

  state_t            state;
  logic [1:0]        kh_idx;
  logic              kh_ones, kh_crc_ok, img_ok, pin_q, blank_q;
  logic [PAGE_W-1:0] len_q;
  logic              prot;

  assign prot          = !(kh_ones && kh_crc_ok);
  assign rd_req        = (state == ST_KH) || (state == ST_LEN) ||
                         (state == ST_ICRCW) || (state == ST_WP);
  assign crc_req       = (state == ST_KHCRC) || (state == ST_ICRC);
  assign crc_img       = (state == ST_ICRC);
  assign crc_last_page = len_q;

  always_comb begin
    case (state)
      ST_KH:    rd_addr = KH_OFS + ADDR_W'({kh_idx, 2'b00});
      ST_LEN:   rd_addr = LEN_OFS;
      ST_ICRCW: rd_addr = ADDR_W'(len_q) * PG + PG - ADDR_W'(4);
      ST_WP:    rd_addr = WP_OFS;
      default:  rd_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      kh_idx    <= '0;
      kh_ones   <= 1'b1;
      kh_crc_ok <= 1'b0;
      img_ok    <= 1'b0;
      pin_q     <= 1'b0;
      blank_q   <= 1'b0;
      len_q     <= '0;
      wp_load   <= 1'b0;
      wp_word   <= '0;
      dbg_en    <= 1'b0;
      acc_class <= ACC_NONE;
      go_user   <= 1'b0;
      go_loader <= 1'b0;
      done      <= 1'b0;
    end else begin
      wp_load <= 1'b0;
      case (state)
        ST_BOOT: begin
          blank_q <= flash_blank;
          if (flash_blank) state <= ST_FINAL;
          else begin
            pin_q <= boot_pin;
            state <= ST_KH;
          end
        end
        ST_KH: if (rd_valid) begin
          kh_ones <= kh_ones && (rd_data == ONES);
          kh_idx  <= kh_idx + 2'd1;
          if (kh_idx == 2'd3) state <= ST_KHCRC;
        end
        ST_KHCRC: if (crc_done) begin
          kh_crc_ok <= crc_ok;
          state     <= ST_LEN;
        end
        ST_LEN: if (rd_valid) begin
          if (rd_data > 32'(MAX_PAGE)) begin
            img_ok <= 1'b0;
            state  <= ST_WP;
          end else begin
            len_q <= rd_data[PAGE_W-1:0];
            state <= ST_ICRCW;
          end
        end
        ST_ICRCW: if (rd_valid) begin
          if (rd_data == ONES) begin
            img_ok <= 1'b1;
            state  <= ST_WP;
          end else state <= ST_ICRC;
        end
        ST_ICRC: if (crc_done) begin
          img_ok <= crc_ok;
          state  <= ST_WP;
        end
        ST_WP: if (rd_valid) begin
          wp_word <= rd_data;
          wp_load <= 1'b1;
          state   <= ST_FINAL;
        end
        ST_FINAL: begin
          done <= 1'b1;
          if (blank_q) begin
            dbg_en    <= 1'b1;
            acc_class <= ACC_FULL;
            go_loader <= 1'b1;
          end else begin
            dbg_en    <= !prot || !img_ok;
            acc_class <= img_ok ? ACC_FULL : ACC_ERASE;
            go_user   <= pin_q && img_ok;
            go_loader <= !(pin_q && img_ok);
          end
          state <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R9
  safe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!dbg_en && acc_class == ACC_NONE && !go_user && !go_loader));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(dbg_en) && $stable(acc_class) && $stable(go_user)));
  // R7
  path_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({go_user, go_loader}) == 1);
  // R5
  user_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_user |-> acc_class == ACC_FULL);
  // R6
  erase_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc_class == ACC_ERASE) |-> dbg_en);
  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, crc_req}));
  // R8
  wp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_load |-> (!done && !blank_q) ##1 !wp_load);
  // R1
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && state != ST_BOOT) |-> (!rd_req && !crc_req && !wp_load));

endmodule

// File: tb/boot_policy_ctrl_bench.sv
module boot_policy_ctrl_bench;
  localparam int ADDR_W = 20;
  localparam int MAX_PAGE = 127;
  localparam int PAGE_W = $clog2(MAX_PAGE + 1);

  logic clk = 0, rst_n = 0, flash_blank = 0, boot_pin = 0;
  logic rd_req, rd_valid = 0, crc_req, crc_img, crc_done = 0, crc_ok = 0;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0] rd_data = 0, wp_word;
  logic [PAGE_W-1:0] crc_last_page;
  logic wp_load, dbg_en, go_user, go_loader, done;
  logic [1:0] acc_class;

  always #5 clk = ~clk;

  boot_policy_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(2048), .MAX_PAGE(MAX_PAGE)) u_boot_policy_ctrl (
    .clk(clk), .rst_n(rst_n), .flash_blank(flash_blank), .boot_pin(boot_pin),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .crc_req(crc_req), .crc_img(crc_img), .crc_last_page(crc_last_page),
    .crc_done(crc_done), .crc_ok(crc_ok), .wp_load(wp_load), .wp_word(wp_word),
    .dbg_en(dbg_en), .acc_class(acc_class), .go_user(go_user),
    .go_loader(go_loader), .done(done));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] kh [4];
  logic [31:0] sc_len, sc_stc, sc_wp;
  bit sc_khok, sc_imok, mon_on = 0;
  bit e_dbg, e_user;
  int e_acc;
  string t_dbg, t_acc;
  logic [ADDR_W-1:0] exp_q[$];
  int rd_cnt = 0, crc_cnt = 0, img_req = 0, wp_cnt = 0;
  logic [31:0] wp_seen;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
    if (a >= 20'h180 && a <= 20'h18C) return kh[(a - 20'h180) >> 2];
    if (a == 20'h194) return sc_len;
    if (a == 20'h19C) return sc_wp;
    if (a == ADDR_W'(sc_len * 32'h800 + 32'h7FC)) return sc_stc;
    return 32'hDEAD_BEEF;
  endfunction

  // flash read responder, latency 2
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_valid = 0; rd_cnt = 0;
    end else if (rd_valid) begin
      rd_valid = 0; rd_cnt = 0;
    end else if (rd_req) begin
      rd_cnt++;
      if (rd_cnt == 2) begin
        if (exp_q.size() == 0) chk(0, "R10", "unexpected read", rd_addr, 0);
        else begin
          logic [ADDR_W-1:0] ea;
          ea = exp_q.pop_front();
          chk(rd_addr == ea, "R10", "read address", rd_addr, ea);
        end
        rd_data = mem_word(rd_addr);
        rd_valid = 1;
      end
    end
  end

  // CRC responder, latency 3
  always @(negedge clk) begin
    if (!rst_n) begin
      crc_done = 0; crc_cnt = 0; img_req = 0;
    end else if (crc_done) begin
      crc_done = 0; crc_cnt = 0;
    end else if (crc_req) begin
      crc_cnt++;
      if (crc_cnt == 3) begin
        if (crc_img) begin
          img_req++;
          chk(crc_last_page == PAGE_W'(sc_len), "R10", "crc last page", crc_last_page, sc_len);
        end
        crc_ok = crc_img ? sc_imok : sc_khok;
        crc_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) wp_cnt = 0;
    else if (wp_load) begin
      wp_cnt++; wp_seen = wp_word;
      chk(!done, "R8", "wp_load before done", done, 0);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      if (!done) begin
        chk(!dbg_en && acc_class == 0 && !go_user && !go_loader, "R9", "safe outputs",
            {dbg_en, acc_class, go_user, go_loader}, 0);
      end else begin
        chk(dbg_en == e_dbg, t_dbg, "dbg_en", dbg_en, e_dbg);
        chk(acc_class == 2'(e_acc), t_acc, "acc_class", acc_class, e_acc);
        chk(go_user == e_user && go_loader == !e_user, "R7", "boot path",
            {go_user, go_loader}, {e_user, !e_user});
      end
    end
  end

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    chk(0, "R9", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic run_case(input bit blank, input bit pin,
                          input logic [31:0] k0, k1, k2, k3, input bit khok,
                          input logic [31:0] len, stc, input bit imok,
                          input logic [31:0] wp);
    bit prot, iok, lenok;
    int exp_img;
    mon_on = 0;
    rst_n = 0;
    flash_blank = blank; boot_pin = pin;
    kh[0] = k0; kh[1] = k1; kh[2] = k2; kh[3] = k3;
    sc_khok = khok; sc_len = len; sc_stc = stc; sc_imok = imok; sc_wp = wp;
    lenok = (len <= MAX_PAGE);
    prot = !((k0 & k1 & k2 & k3) == 32'hFFFF_FFFF && khok);
    iok = lenok && (stc == 32'hFFFF_FFFF || imok);
    exp_q.delete();
    exp_img = 0;
    if (blank) begin
      e_dbg = 1; e_acc = 2; e_user = 0; t_dbg = "R1"; t_acc = "R1";
    end else begin
      e_dbg = !prot || !iok;
      e_acc = iok ? 2 : 1;
      e_user = pin && iok;
      t_dbg = (prot && !iok) ? "R6" : (prot ? "R3" : "R2");
      t_acc = iok ? "R4" : "R5";
      for (int i = 0; i < 4; i++) exp_q.push_back(ADDR_W'(32'h180 + 4 * i));
      exp_q.push_back(ADDR_W'(32'h194));
      if (lenok) exp_q.push_back(ADDR_W'(len * 32'h800 + 32'h7FC));
      exp_q.push_back(ADDR_W'(32'h19C));
      if (lenok && stc != 32'hFFFF_FFFF) exp_img = 1;
    end
    repeat (3) @(negedge clk);
    chk(!done && !dbg_en && acc_class == 0 && !go_user && !go_loader, "R9",
        "reset state", {done, dbg_en, acc_class, go_user, go_loader}, 0);
    rst_n = 1;
    mon_on = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done, "R9", "done reached", done, 1);
    repeat (5) @(negedge clk);
    mon_on = 0;
    chk(done, "R9", "done held", done, 1);
    chk(exp_q.size() == 0, blank ? "R1" : "R10", "reads outstanding", exp_q.size(), 0);
    chk(img_req == exp_img, blank ? "R1" : "R4", "image crc requests", img_req, exp_img);
    chk(wp_cnt == (blank ? 0 : 1), blank ? "R1" : "R8", "wp_load count", wp_cnt, blank ? 0 : 1);
    if (!blank) chk(wp_seen == wp, "R8", "wp_word", wp_seen, wp);
  endtask

  localparam logic [31:0] F = 32'hFFFF_FFFF;

  initial begin
    // R1 blank part, pin ignored
    run_case(1, 1, F, F, F, F, 1, F, F, 1, F);
    run_case(1, 0, 32'h0, 32'h1, F, F, 0, 32'h999, 32'h0, 0, 32'h0);
    // R2 R7 unprotected, image ok, pin high then low
    run_case(0, 1, F, F, F, F, 1, 32'd5, 32'h1234_5678, 1, 32'h0000_000F);
    run_case(0, 0, F, F, F, F, 1, 32'd5, 32'h1234_5678, 1, 32'hA5A5_0001);
    // R3 protected by key-hash value, then by key-hash CRC
    run_case(0, 1, 32'h4398_C650, F, F, F, 1, 32'd0, 32'h0BAD_F00D, 1, 32'h8000_0000);
    run_case(0, 1, F, F, F, F, 0, 32'd127, 32'h0BAD_F00D, 1, 32'h1);
    // R4 CRC disabled by all-ones word
    run_case(0, 1, F, F, F, F, 1, 32'd3, F, 0, 32'hFFFF_0000);
    run_case(0, 1, 32'h1, 32'h2, 32'h3, 32'h4, 1, 32'd2, F, 0, 32'h0);
    // R5 R6 image CRC failure
    run_case(0, 1, 32'h1, 32'h2, 32'h3, 32'h4, 1, 32'd5, 32'h0000_0001, 0, 32'h3);
    run_case(0, 1, F, F, F, F, 1, 32'd1, 32'h0000_0001, 0, 32'h7);
    // R5 page count out of range
    run_case(0, 1, 32'h1, F, F, F, 1, 32'd128, 32'h0, 1, 32'h55);
    run_case(0, 0, F, F, F, F, 1, 32'd200, F, 1, 32'hC3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule